// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block sits on the host side of a 14-bit sampling converter that returns its result over a serial line. When the host raises `start`, the controller drives the convert-start pin low for a fixed number of cycles. The falling edge moves the converter's sampler from sample to hold. The controller then watches the converter's busy flag. It waits for busy to rise and then for it to fall again, which marks the end of conversion. After that it lowers the active-low read enable, waits one setup cycle, and issues a 16-pulse serial clock. The serial clock comes from the system clock through a parameterised divider.

On every rising serial-clock edge the controller samples the data line. The converter presents the result most significant bit first, followed by zero-filled trailing positions. The controller keeps the first 14 bits as the result and checks that the trailing fill bits are zero. A one-cycle `res_valid` pulse carries the word, and `res_frame_err` is raised in the same cycle if a fill bit was one. If busy does not complete within a parameterised window, the controller returns to idle and pulses `res_timeout` instead. Chip select is assumed to be held active outside the block.

The block can also generate a conversion clock for the converter. When `cnv_clk_ext` is high it outputs a divided square wave, and when `cnv_clk_ext` is low it holds that output low.

The state machine has eight states:

- `ST_IDLE`: waiting for `start`.
- `ST_STROBE`: convert-start is held low.
- `ST_WAIT_HI`: waiting for busy to rise.
- `ST_WAIT_LO`: waiting for busy to fall.
- `ST_SETUP`: read enable is low, and this is the one setup cycle.
- `ST_SHIFT`: the serial clock runs.
- `ST_DONE`: the result-valid pulse.
- `ST_FAULT`: the timeout pulse.

The transitions are:

- idle→strobe on `start`.
- strobe→wait-hi after `CNV_LO` cycles.
- wait-hi→wait-lo when busy is high.
- wait-lo→setup when busy is low.
- wait-hi or wait-lo→fault when the timeout expires.
- setup→shift always.
- shift→done on the falling serial-clock edge that follows the 16th rising edge.
- done→idle and fault→idle always.

Top module: `adc_rdout_ctrl`

## Requirements
- R1: While reset is asserted and right after it: `adc_cnv_n`=1, `adc_rd_n`=1, `adc_sclk`=0, `res_valid`=0, `res_timeout`=0.
- R2: A `start` sampled high in idle drives `adc_cnv_n` low for exactly `CNV_LO` consecutive cycles.
- R3: Read enable (`adc_rd_n`) stays high until busy has risen and then fallen again. It is never low while `adc_busy` is high.
- R4: Each frame has exactly `FRAME_LEN` (16) rising `adc_sclk` edges while `adc_rd_n` is low. Read enable goes low `SCLK_HALF`+1 cycles before the first rising edge.
- R5: `adc_sclk` is low whenever `adc_rd_n` is high. Within a frame, each high phase and each later low phase lasts `SCLK_HALF` cycles.
- R6: The bit sampled at the k-th rising edge (k=1..14) becomes `res_data[14-k]`, so the first bit is the MSB. The result is presented with a one-cycle `res_valid` in the cycle in which `adc_rd_n` returns high.
- R7: `res_frame_err` is 1 exactly when `res_valid` is 1 and either of the bits sampled at rising edges 15 and 16 was 1.
- R8: If the busy rise-then-fall has not completed `BUSY_TMO` cycles after `adc_cnv_n` rises, then `res_timeout` pulses for one cycle at exactly that cycle and no `res_valid` is produced.
- R9: A `start` outside idle is ignored: one transaction produces one convert-start pulse and one result.
- R10: With `cnv_clk_ext`=1, `adc_cnv_clk` is a square wave of period 2·`CNVCLK_HALF` cycles. With `cnv_clk_ext`=0, it is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Conversion request, sampled in idle |
| cnv_clk_ext | input | 1 | 1 = drive the conversion clock output, 0 = hold it low |
| adc_busy | input | 1 | Converter busy flag, high while converting |
| adc_sdo | input | 1 | Converter serial data |
| adc_cnv_n | output | 1 | Convert-start strobe, active low |
| adc_rd_n | output | 1 | Read enable, active low |
| adc_sclk | output | 1 | Serial data clock |
| adc_cnv_clk | output | 1 | Conversion clock for the converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | DATA_W | Captured result word |
| res_frame_err | output | 1 | Nonzero fill bits seen in this frame |
| res_timeout | output | 1 | One-cycle busy timeout strobe |

## Verification
The bench builds the controller with `SCLK_HALF`=3, `CNV_LO`=3, `BUSY_TMO`=64 and `CNVCLK_HALF`=5. The short timeout makes the fault path reachable in a few dozen cycles, and the bench measures its exact cycle count. The odd serial half-period exposes off-by-one errors in phase widths and in the setup gap. A bench model of the converter raises busy for a random 5 to 40 cycles, well inside the timeout. It shifts out a random word with occasionally nonzero fill bits, and keeps returning zeros past bit 16. A directed case issues a second `start` during the busy wait.

// File: rtl/adc_rdout_pkg.sv
package adc_rdout_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_STROBE  = 3'd1,
        ST_WAIT_HI = 3'd2,
        ST_WAIT_LO = 3'd3,
        ST_SETUP   = 3'd4,
        ST_SHIFT   = 3'd5,
        ST_DONE    = 3'd6,
        ST_FAULT   = 3'd7
    } rd_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rdout_sclk_gen.sv
module rdout_sclk_gen #(
    parameter int unsigned HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int unsigned PW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [PW-1:0] LAST = PW'(HALF - 1);

    logic [PW-1:0] ph_q;
    logic          sclk_q;
    logic          at_last;

    assign at_last = (ph_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ph_q   <= '0;
            sclk_q <= 1'b0;
        end else if (at_last) begin
            ph_q   <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    assign sclk      = sclk_q;
    assign rise_tick = run && at_last && !sclk_q;
    assign fall_tick = run && at_last && sclk_q;

endmodule

// File: rtl/rdout_shifter.sv
module rdout_shifter #(
    parameter int unsigned FRAME = 16,
    parameter int unsigned DATA  = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            capture,
    input  logic            sdi,
    output logic            frame_full,
    output logic [DATA-1:0] data,
    output logic            fill_bad
);
    localparam int unsigned CW     = $clog2(FRAME + 1);
    localparam int unsigned FILL_W = FRAME - DATA;

    logic [FRAME-1:0] sh_q;
    logic [CW-1:0]    cnt_q;

    assign frame_full = (cnt_q == CW'(FRAME));

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (capture && !frame_full) begin
            sh_q  <= {sh_q[FRAME-2:0], sdi};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign data = sh_q[FRAME-1 -: DATA];

    generate
        if (FILL_W > 0) begin : g_fill
            assign fill_bad = |sh_q[FILL_W-1:0];
        end else begin : g_nofill
            assign fill_bad = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/rdout_cnvclk.sv
module rdout_cnvclk #(
    parameter int unsigned HALF   = 8,
    parameter bit          ENABLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_sel,
    output logic cnv_clk
);
    generate
        if (ENABLE) begin : g_div
            localparam int unsigned PW = (HALF > 1) ? $clog2(HALF) : 1;
            logic [PW-1:0] ph_q;
            logic          ck_q;
            always_ff @(posedge clk) begin
                if (!rst_n || !ext_sel) begin
                    ph_q <= '0;
                    ck_q <= 1'b0;
                end else if (ph_q == PW'(HALF - 1)) begin
                    ph_q <= '0;
                    ck_q <= ~ck_q;
                end else begin
                    ph_q <= ph_q + 1'b1;
                end
            end
            assign cnv_clk = ck_q;
        end else begin : g_off
            logic unused_in;
            assign unused_in = ^{clk, rst_n, ext_sel};
            assign cnv_clk   = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/adc_rdout_ctrl.sv
module adc_rdout_ctrl
    import adc_rdout_pkg::*;
#(
    parameter int unsigned DATA_W      = 14,
    parameter int unsigned FRAME_LEN   = 16,
    parameter int unsigned SCLK_HALF   = 4,
    parameter int unsigned CNV_LO      = 3,
    parameter int unsigned BUSY_TMO    = 4096,
    parameter int unsigned CNVCLK_HALF = 8,
    parameter bit          HAS_CNVCLK  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cnv_clk_ext,
    input  logic              adc_busy,
    input  logic              adc_sdo,
    output logic              adc_cnv_n,
    output logic              adc_rd_n,
    output logic              adc_sclk,
    output logic              adc_cnv_clk,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              res_frame_err,
    output logic              res_timeout
);
    localparam int unsigned TMAX = max2(BUSY_TMO, CNV_LO);
    localparam int unsigned TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] STROBE_END = TW'(CNV_LO - 1);
    localparam logic [TW-1:0] TMO_END    = TW'(BUSY_TMO - 1);
    localparam logic [TW-1:0] TSAT       = TW'(TMAX);

    rd_state_e   state_q, state_d;
    logic [TW-1:0] tmr_q;
    logic        tmr_clr;
    logic        sclk_run, rise_tick, fall_tick;
    logic        frame_full, fill_bad, shift_clr;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_STROBE;
            ST_STROBE:  if (tmr_q == STROBE_END) state_d = ST_WAIT_HI;
            ST_WAIT_HI: begin
                if (tmr_q == TMO_END) state_d = ST_FAULT;
                else if (adc_busy)    state_d = ST_WAIT_LO;
            end
            ST_WAIT_LO: begin
                if (tmr_q == TMO_END) state_d = ST_FAULT;
                else if (!adc_busy)   state_d = ST_SETUP;
            end
            ST_SETUP:   state_d = ST_SHIFT;
            ST_SHIFT:   if (frame_full && fall_tick) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            ST_FAULT:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // shared timer: restarts on entry to strobe and to the busy wait
    assign tmr_clr = (state_d != state_q) &&
                     ((state_d == ST_STROBE) || (state_d == ST_WAIT_HI));

    always_ff @(posedge clk) begin
        if (!rst_n || tmr_clr) tmr_q <= '0;
        else if (tmr_q != TSAT) tmr_q <= tmr_q + 1'b1;
    end

    // output decode
    always_comb begin
        adc_cnv_n   = 1'b1;
        adc_rd_n    = 1'b1;
        res_valid   = 1'b0;
        res_timeout = 1'b0;
        sclk_run    = 1'b0;
        shift_clr   = 1'b0;
        unique case (state_q)
            ST_STROBE: adc_cnv_n = 1'b0;
            ST_SETUP: begin
                adc_rd_n  = 1'b0;
                shift_clr = 1'b1;
            end
            ST_SHIFT: begin
                adc_rd_n = 1'b0;
                sclk_run = 1'b1;
            end
            ST_DONE:  res_valid   = 1'b1;
            ST_FAULT: res_timeout = 1'b1;
            default: ;
        endcase
    end

    rdout_sclk_gen #(.HALF(SCLK_HALF)) u_sclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (sclk_run),
        .sclk      (adc_sclk),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    rdout_shifter #(.FRAME(FRAME_LEN), .DATA(DATA_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (shift_clr),
        .capture    (rise_tick),
        .sdi        (adc_sdo),
        .frame_full (frame_full),
        .data       (res_data),
        .fill_bad   (fill_bad)
    );

    assign res_frame_err = res_valid && fill_bad;

    rdout_cnvclk #(.HALF(CNVCLK_HALF), .ENABLE(HAS_CNVCLK)) u_cnvclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_sel (cnv_clk_ext),
        .cnv_clk (adc_cnv_clk)
    );

endmodule

// File: rtl/adc_rdout_ctrl_chk.sv
module adc_rdout_ctrl_chk #(
    parameter int unsigned CNV_LO    = 3,
    parameter int unsigned FRAME_LEN = 16
) (
    input logic clk,
    input logic rst_n,
    input logic cnv_clk_ext,
    input logic adc_busy,
    input logic adc_cnv_n,
    input logic adc_rd_n,
    input logic adc_sclk,
    input logic adc_cnv_clk,
    input logic res_valid,
    input logic res_frame_err,
    input logic res_timeout
);
    localparam int unsigned LW = $clog2(CNV_LO + 1) + 1;
    localparam int unsigned RW = $clog2(FRAME_LEN + 1) + 1;

    logic [LW-1:0] lo_cnt;
    logic [RW-1:0] rise_cnt;
    logic          sclk_prev;

    always_ff @(posedge clk) begin
        if (!rst_n || adc_cnv_n) lo_cnt <= '0;
        else                     lo_cnt <= lo_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_cnt  <= '0;
            sclk_prev <= 1'b0;
        end else begin
            sclk_prev <= adc_sclk;
            if (adc_rd_n)                   rise_cnt <= '0;
            else if (adc_sclk && !sclk_prev) rise_cnt <= rise_cnt + 1'b1;
        end
    end

    p_strobe_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_cnv_n |-> (lo_cnt < LW'(CNV_LO)));

    p_strobe_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cnv_n) |-> (lo_cnt == LW'(CNV_LO)));

    p_no_read_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rd_n |-> !adc_busy);

    p_frame_rises_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_rd_n) |-> (rise_cnt == RW'(FRAME_LEN)));

    p_sclk_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        adc_rd_n |-> !adc_sclk);

    p_valid_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $rose(adc_rd_n));

    p_err_qualified_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_frame_err |-> res_valid);

    p_timeout_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_timeout |-> (!res_valid && adc_cnv_n && adc_rd_n));

    p_cnvclk_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cnv_clk_ext |=> !adc_cnv_clk);

endmodule

bind adc_rdout_ctrl adc_rdout_ctrl_chk #(
    .CNV_LO    (CNV_LO),
    .FRAME_LEN (FRAME_LEN)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cnv_clk_ext   (cnv_clk_ext),
    .adc_busy      (adc_busy),
    .adc_cnv_n     (adc_cnv_n),
    .adc_rd_n      (adc_rd_n),
    .adc_sclk      (adc_sclk),
    .adc_cnv_clk   (adc_cnv_clk),
    .res_valid     (res_valid),
    .res_frame_err (res_frame_err),
    .res_timeout   (res_timeout)
);

// File: tb/adc_rdout_ctrl_tb.sv
module adc_rdout_ctrl_tb;
    localparam int SH  = 3;
    localparam int CL  = 3;
    localparam int TMO = 64;
    localparam int CKH = 5;
    localparam int DW  = 14;
    localparam int FL  = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, start = 1'b0, cnv_clk_ext = 1'b0, adc_busy = 1'b0;
    logic adc_sdo, adc_cnv_n, adc_rd_n, adc_sclk, adc_cnv_clk;
    logic res_valid, res_frame_err, res_timeout;
    logic [DW-1:0] res_data;

    int n_chk = 0, n_fail = 0;

    adc_rdout_ctrl #(
        .DATA_W(DW), .FRAME_LEN(FL), .SCLK_HALF(SH), .CNV_LO(CL),
        .BUSY_TMO(TMO), .CNVCLK_HALF(CKH), .HAS_CNVCLK(1'b1)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cnv_clk_ext(cnv_clk_ext),
        .adc_busy(adc_busy), .adc_sdo(adc_sdo), .adc_cnv_n(adc_cnv_n),
        .adc_rd_n(adc_rd_n), .adc_sclk(adc_sclk), .adc_cnv_clk(adc_cnv_clk),
        .res_valid(res_valid), .res_data(res_data),
        .res_frame_err(res_frame_err), .res_timeout(res_timeout)
    );

    // converter model: busy window, MSB-first frame, endless zero fill
    logic [DW-1:0] m_word = '0;
    logic [1:0]    m_fill = '0;
    logic [FL-1:0] m_sh   = '0;
    int            m_len  = 10;
    bit            m_en   = 1'b0;
    int            bitpos = 0;

    assign adc_sdo = adc_rd_n ? 1'b1 : ((bitpos < FL) ? m_sh[FL-1-bitpos] : 1'b0);

    always @(negedge adc_cnv_n) begin
        if (m_en) begin
            m_sh = {m_word, m_fill};
            repeat (2) @(posedge clk);
            #1 adc_busy = 1'b1;
            repeat (m_len) @(posedge clk);
            #1 adc_busy = 1'b0;
        end
    end

    always @(negedge adc_sclk or posedge adc_rd_n) begin
        if (adc_rd_n) bitpos = 0;
        else          bitpos = bitpos + 1;
    end

    // pin monitor, sampled 2 ns after each rising edge
    int  mon_rises = 0, mon_phase_bad = 0, mon_lo_len = 0, mon_lo_run = 0;
    int  mon_cnv_falls = 0, mon_rd_busy = 0, mon_gate_bad = 0, run = 0;
    logic psclk = 1'b0, pcnv = 1'b1;

    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (!adc_cnv_n) mon_lo_run++;
            if (adc_cnv_n && !pcnv) mon_lo_len = mon_lo_run;
            if (adc_cnv_n) mon_lo_run = 0;
            if (!adc_cnv_n && pcnv) mon_cnv_falls++;
            if (!adc_rd_n && adc_busy) mon_rd_busy++;
            if (adc_rd_n && adc_sclk) mon_gate_bad++;
            if (adc_rd_n) run = 0;
            else if (adc_sclk != psclk) begin
                if (psclk && run != SH) mon_phase_bad++;
                if (!psclk && mon_rises == 0 && run != SH + 1) mon_phase_bad++;
                if (!psclk && mon_rises != 0 && run != SH) mon_phase_bad++;
                if (adc_sclk) mon_rises++;
                run = 1;
            end else run++;
            psclk = adc_sclk;
            pcnv  = adc_cnv_n;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_err(input logic [1:0] fill);
        return fill != 2'b00;
    endfunction

    task automatic clear_mon();
        mon_rises = 0; mon_phase_bad = 0; mon_lo_len = 0;
        mon_cnv_falls = 0; mon_rd_busy = 0; mon_gate_bad = 0;
    endtask

    task automatic run_conv(input logic [DW-1:0] w, input logic [1:0] f,
                            input int len, input bit extra);
        bit got = 0;
        int nvalid = 0;
        logic [DW-1:0] d = '0;
        logic e = 1'b0;
        m_word = w; m_fill = f; m_len = len; m_en = 1'b1;
        @(negedge clk); clear_mon();
        start = 1'b1; @(negedge clk); start = 1'b0;
        if (extra) begin
            repeat (6) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
        end
        for (int i = 0; i < 3000 && !got; i++) begin
            @(negedge clk);
            if (res_valid) begin got = 1; nvalid++; d = res_data; e = res_frame_err; end
            if (res_timeout) got = 1;
        end
        repeat (4) @(negedge clk);
        if (res_valid) nvalid++;
        chk(got && nvalid == 1, "R6 one valid per frame", nvalid, 1);
        chk(d == w, "R6 data MSB first", int'(d), int'(w));
        chk(e == exp_err(f), "R7 fill-bit error", int'(e), int'(exp_err(f)));
        chk(mon_rises == FL, "R4 rising edges per frame", mon_rises, FL);
        chk(mon_phase_bad == 0, "R4/R5 sclk phases and setup gap", mon_phase_bad, 0);
        chk(mon_gate_bad == 0, "R5 sclk gated by read enable", mon_gate_bad, 0);
        chk(mon_lo_len == CL, "R2 strobe length", mon_lo_len, CL);
        chk(mon_rd_busy == 0, "R3 no read while busy", mon_rd_busy, 0);
        if (extra) chk(mon_cnv_falls == 1, "R9 extra start ignored", mon_cnv_falls, 1);
    endtask

    task automatic run_timeout();
        int n = 0;
        bit seen_v = 0;
        m_en = 1'b0;
        @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
        while (!adc_cnv_n) @(negedge clk);
        for (int i = 0; i < 4 * TMO && !res_timeout; i++) begin
            @(negedge clk); n++;
            if (res_valid) seen_v = 1;
        end
        chk(n == TMO, "R8 timeout cycle", n, TMO);
        chk(!seen_v, "R8 no valid on timeout", int'(seen_v), 0);
        @(negedge clk);
        chk(!res_timeout, "R8 timeout one cycle", int'(res_timeout), 0);
    endtask

    task automatic check_cnvclk();
        int per = 0;
        int highs = 0;
        logic p;
        cnv_clk_ext = 1'b1;
        repeat (3) @(negedge clk);
        p = adc_cnv_clk;
        while (!(adc_cnv_clk && !p)) begin p = adc_cnv_clk; @(negedge clk); end
        p = adc_cnv_clk;
        @(negedge clk); per = 1;
        while (!(adc_cnv_clk && !p) && per < 100) begin p = adc_cnv_clk; @(negedge clk); per++; end
        chk(per == 2 * CKH, "R10 conversion clock period", per, 2 * CKH);
        cnv_clk_ext = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (adc_cnv_clk) highs++;
        end
        chk(highs == 0, "R10 conversion clock held low", highs, 0);
    endtask

    initial begin : watchdog
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'd7321);
        repeat (3) @(negedge clk);
        chk(adc_cnv_n && adc_rd_n && !adc_sclk && !res_valid && !res_timeout,
            "R1 reset pins", {adc_cnv_n, adc_rd_n, adc_sclk, res_valid, res_timeout}, 5'b11000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(adc_cnv_n && adc_rd_n && !adc_sclk && !res_valid,
            "R1 idle after reset", {adc_cnv_n, adc_rd_n, adc_sclk, res_valid}, 4'b1100);
        // directed corners
        run_conv(14'h3FFF, 2'b00, 5, 1'b0);
        run_conv(14'h0000, 2'b00, 40, 1'b0);
        run_conv(14'h2001, 2'b01, 7, 1'b0);
        run_conv(14'h1555, 2'b10, 12, 1'b0);
        run_conv(14'h2AAA, 2'b00, 20, 1'b1);
        run_timeout();
        run_conv(14'h0F0F, 2'b00, 9, 1'b0);
        check_cnvclk();
        // random traffic
        for (int k = 0; k < 24; k++) begin
            logic [DW-1:0] w;
            logic [1:0] f;
            w = DW'($urandom);
            f = (($urandom % 5) == 0) ? 2'($urandom % 3 + 1) : 2'b00;
            run_conv(w, f, 5 + int'($urandom % 36), ($urandom % 6) == 0);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule